// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address and write-control front end of a synchronous burst SRAM, delivered together with a behavioural storage array. Every control input is sampled on the rising clock edge. A cycle that carries an active burst-start strobe latches the external address. Each later cycle that has the advance input asserted moves to the next beat of a four-beat burst. The next beat comes from a 2-bit counter that wraps and runs in either linear or XOR-interleaved order. When advance is deasserted, the current address is held.

Two start strobes exist. The processor-side strobe is obeyed only while chip enable is asserted. It wins when both strobes arrive together, and the cycle it starts performs no write. The controller-side strobe loads regardless of chip enable, and it accepts a write in the same cycle. Bursting is optional: a new address may be loaded on every cycle.

The write decode turns a global write, a byte-write enable and per-byte strobes into one write enable per byte. Global write overrides the byte-level inputs. A write lands at the address that `cur_addr` takes after the same edge, and `rdata` always shows the word at `cur_addr`.

Top module: `burst_sram_seq`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `cur_addr` is 0 and the burst counter is 0.
- R2: An edge with `start_ctl_n` low, or with both `start_cpu_n` and `ce_n` low, loads `addr_in` into `cur_addr` and clears the beat count. Loading on every consecutive cycle is allowed, and `adv_n` is ignored in a load cycle.
- R3: With `linear_order` = 1, each edge with `adv_n` low and no load advances the beat count by one. `cur_addr[1:0]` is then (start + beat) mod 4, where start is the loaded `addr_in[1:0]`. It wraps after the fourth beat and keeps counting.
- R4: With `linear_order` = 0, `cur_addr[1:0]` is start XOR beat.
- R5: An edge with `adv_n` high and no load leaves the beat count unchanged, so `cur_addr` holds while the mode is unchanged.
- R6: Without a load, `cur_addr[ADDR_W-1:2]` never changes.
- R7: When both start strobes are low with `ce_n` low, the processor strobe takes priority. No byte is written at that edge.
- R8: While `ce_n` is high, `start_cpu_n` has no effect. The counter advances or holds as usual, and the controller strobe still loads and writes.
- R9: With `gwr_n` high, byte i (bits [8i+7:8i]) is written when `bwe_n` and `bsel_n[i]` are both low.
- R10: With `gwr_n` low, all bytes are written regardless of `bwe_n` and `bsel_n`.
- R11: A write goes to the address `cur_addr` holds after that edge, and `rdata` is the stored word at `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable, gates the processor strobe |
| start_cpu_n | input | 1 | Active-low processor-side burst start |
| start_ctl_n | input | 1 | Active-low controller-side burst start |
| adv_n | input | 1 | Active-low burst advance |
| linear_order | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_in | input | ADDR_W | External word address |
| bwe_n | input | 1 | Active-low byte-write enable |
| bsel_n | input | BYTES | Active-low per-byte write strobes |
| gwr_n | input | 1 | Active-low global write |
| wdata | input | BYTES*BYTE_W | Write data |
| cur_addr | output | ADDR_W | Current burst address |
| rdata | output | BYTES*BYTE_W | Stored word at `cur_addr` |

## Verification
The bench builds the block with ADDR_W = 8, BYTES = 2 and BYTE_W = 8. At that size all 256 words are filled at full load rate, and every start offset is run through more than one wrap in both burst orders. All sixteen combinations of global write, byte-write enable and the two byte strobes are applied. The strobe-priority and chip-enable cases are checked against a reference model that follows the requirement arithmetic directly.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    // Low address bits for a beat: linear adds, interleaved XORs.
    function automatic logic [BEAT_W-1:0] burst_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        return linear ? BEAT_W'(start + beat) : (start ^ beat);
    endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_d,
    output logic [AW-1:0] addr_q
);
    localparam int UW = AW - BEAT_W;

    typedef struct packed {
        logic [UW-1:0]     upper;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] low;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.upper = addr_in[AW-1:BEAT_W];
            st_d.start = addr_in[BEAT_W-1:0];
            st_d.beat  = '0;
        end else if (adv) begin
            st_d.beat  = st_q.beat + 1'b1;
        end
        st_d.low = burst_low(st_d.start, st_d.beat, linear);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_d = {st_d.upper, st_d.low};
    assign addr_q = {st_q.upper, st_q.low};
endmodule

// File: rtl/byte_write_dec.sv
module byte_write_dec #(
    parameter int NB = 2
) (
    input  logic          block,
    input  logic          gwr_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bsel_n,
    output logic [NB-1:0] we
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign we[i] = !block && (!gwr_n || (!bwe_n && !bsel_n[i]));
    end
endmodule

// File: rtl/burst_mem_array.sv
module burst_mem_array #(
    parameter int AW = 8,
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic [AW-1:0]    waddr,
    input  logic [NB-1:0]    we,
    input  logic [NB*BW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [NB*BW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NB; i++) begin
            if (we[i]) mem[waddr][i*BW +: BW] <= wdata[i*BW +: BW];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    start_cpu_n,
    input  logic                    start_ctl_n,
    input  logic                    adv_n,
    input  logic                    linear_order,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic                    bwe_n,
    input  logic [BYTES-1:0]        bsel_n,
    input  logic                    gwr_n,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    output logic [ADDR_W-1:0]       cur_addr,
    output logic [BYTES*BYTE_W-1:0] rdata
);
    logic              cpu_load;
    logic              any_load;
    logic [ADDR_W-1:0] next_addr;
    logic [BYTES-1:0]  byte_we;

    assign cpu_load = !ce_n && !start_cpu_n;
    assign any_load = cpu_load || !start_ctl_n;

    burst_addr_gen #(.AW(ADDR_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (any_load),
        .adv     (!adv_n),
        .linear  (linear_order),
        .addr_in (addr_in),
        .addr_d  (next_addr),
        .addr_q  (cur_addr)
    );

    byte_write_dec #(.NB(BYTES)) u_dec (
        .block  (cpu_load),
        .gwr_n  (gwr_n),
        .bwe_n  (bwe_n),
        .bsel_n (bsel_n),
        .we     (byte_we)
    );

    burst_mem_array #(.AW(ADDR_W), .NB(BYTES), .BW(BYTE_W)) u_mem (
        .clk   (clk),
        .waddr (next_addr),
        .we    (byte_we),
        .wdata (wdata),
        .raddr (cur_addr),
        .rdata (rdata)
    );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int AW = 8,
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          start_cpu_n,
    input logic          start_ctl_n,
    input logic          adv_n,
    input logic          linear_order,
    input logic [AW-1:0] addr_in,
    input logic          gwr_n,
    input logic          bwe_n,
    input logic [AW-1:0] cur_addr,
    input logic [NB-1:0] byte_we
);
    logic ld_cpu, ld_any;
    assign ld_cpu = !ce_n && !start_cpu_n;
    assign ld_any = ld_cpu || !start_ctl_n;

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ld_any |=> cur_addr == $past(addr_in)); // R2
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_any && !adv_n && linear_order && $stable(linear_order))
        |=> cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)); // R3
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_any && adv_n && $stable(linear_order)) |=> $stable(cur_addr)); // R5
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_any |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R6
    AST_CPU_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cpu |-> byte_we == '0); // R7
    AST_CE_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && start_ctl_n && adv_n && $stable(linear_order)) |=> $stable(cur_addr)); // R8
    AST_NO_BYTE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (gwr_n && bwe_n) |-> byte_we == '0); // R9
    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!gwr_n && !ld_cpu) |-> &byte_we); // R10
endmodule

bind burst_sram_seq burst_seq_chk #(.AW(ADDR_W), .NB(BYTES)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .start_cpu_n  (start_cpu_n),
    .start_ctl_n  (start_ctl_n),
    .adv_n        (adv_n),
    .linear_order (linear_order),
    .addr_in      (addr_in),
    .gwr_n        (gwr_n),
    .bwe_n        (bwe_n),
    .cur_addr     (cur_addr),
    .byte_we      (byte_we)
);

// File: tb/test_burst_sram_seq.sv
module test_burst_sram_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, start_cpu_n = 1'b1, start_ctl_n = 1'b1, adv_n = 1'b1;
    logic        linear_order = 1'b1;
    logic [7:0]  addr_in = '0;
    logic        bwe_n = 1'b1, gwr_n = 1'b1;
    logic [1:0]  bsel_n = 2'b11;
    logic [15:0] wdata = '0;
    logic [7:0]  cur_addr;
    logic [15:0] rdata;

    int checks = 0, errors = 0;
    logic [1:0]  m_start = '0, m_beat = '0;
    logic [5:0]  m_upper = '0;
    logic [7:0]  m_cur = '0;
    logic [15:0] m_mem [256];

    always #2.5 clk = ~clk;

    burst_sram_seq i_burst_sram_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .start_cpu_n(start_cpu_n),
        .start_ctl_n(start_ctl_n), .adv_n(adv_n), .linear_order(linear_order),
        .addr_in(addr_in), .bwe_n(bwe_n), .bsel_n(bsel_n), .gwr_n(gwr_n),
        .wdata(wdata), .cur_addr(cur_addr), .rdata(rdata)
    );

    task automatic check_addr(input string tag, input logic [7:0] exp);
        checks++;
        if (cur_addr !== exp) begin
            errors++;
            $display("FAIL %s cur_addr=%h expected=%h", tag, cur_addr, exp);
        end
    endtask

    task automatic step(input string tag, input logic ce, cpu, ctl, adv, lin,
                        input logic [7:0] a, input logic bwe, input logic [1:0] bs,
                        input logic gw, input logic [15:0] wd);
        logic ldc, ld;
        ce_n = ce; start_cpu_n = cpu; start_ctl_n = ctl; adv_n = adv;
        linear_order = lin; addr_in = a; bwe_n = bwe; bsel_n = bs;
        gwr_n = gw; wdata = wd;
        @(posedge clk);
        ldc = !ce && !cpu;
        ld  = ldc || !ctl;
        if (ld) begin
            m_upper = a[7:2]; m_start = a[1:0]; m_beat = 2'd0;
        end else if (!adv) begin
            m_beat = m_beat + 2'd1;
        end
        m_cur = {m_upper, lin ? 2'((m_start + m_beat) % 4) : (m_start ^ m_beat)};
        if (!ldc) begin
            for (int i = 0; i < 2; i++)
                if (!gw || (!bwe && !bs[i])) m_mem[m_cur][i*8 +: 8] = wd[i*8 +: 8];
        end
        #1;
        check_addr(tag, m_cur);
        checks++;
        if (rdata !== m_mem[m_cur]) begin
            errors++;
            $display("FAIL %s rdata=%h expected=%h", tag, rdata, m_mem[m_cur]);
        end
    endtask

    initial begin : watchdog
        #900000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check_addr("R1 reset", 8'h00);
        rst_n = 1'b1;
        @(posedge clk);
        #1 check_addr("R1 after reset", 8'h00);

        // R2 / R10: full-rate loads with global write fill every word
        for (int a = 0; a < 256; a++)
            step("R2 R10 fill", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'(a), 1'b1, 2'b11, 1'b0,
                 16'(a * 257) ^ 16'h5a3c);

        // R3 / R4 / R5 / R6: every start offset, both orders, wrap and suspend
        for (int lin = 0; lin < 2; lin++) begin
            for (int s = 0; s < 4; s++) begin
                logic [7:0] base;
                base = {6'(lin * 4 + s + 9), 2'(s)};
                if (s[0])
                    step("R2 cpu load", 1'b0, 1'b0, 1'b1, 1'b0, 1'(lin), base, 1'b1, 2'b11, 1'b1, '0);
                else
                    step("R2 ctl load", 1'b1, 1'b1, 1'b0, 1'b0, 1'(lin), base, 1'b1, 2'b11, 1'b1, '0);
                for (int b = 0; b < 6; b++)
                    step(lin ? "R3 R6 linear" : "R4 R6 interleave", 1'b1, 1'b1, 1'b1, 1'b0,
                         1'(lin), 8'hff, 1'b1, 2'b11, 1'b1, '0);
                for (int h = 0; h < 2; h++)
                    step("R5 suspend", 1'b1, 1'b1, 1'b1, 1'b1, 1'(lin), 8'h00, 1'b1, 2'b11, 1'b1, '0);
                step(lin ? "R3 resume" : "R4 resume", 1'b1, 1'b1, 1'b1, 1'b0, 1'(lin),
                     8'h00, 1'b1, 2'b11, 1'b1, '0);
            end
        end

        // R9 / R10 / R11: all write-control combinations
        for (int p = 0; p < 16; p++)
            step(p[3] ? "R9 byte write" : "R10 global write", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1,
                 8'(8'h80 + p), p[0], 2'(p >> 1), p[3], 16'(16'hc000 + p * 16'h0111));

        // R11: writes during an advancing burst land on the advanced address
        step("R11 load", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h92, 1'b1, 2'b11, 1'b1, '0);
        for (int b = 0; b < 4; b++)
            step("R11 burst write", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0,
                 2'(b), 1'b1, 16'(16'h7700 + b));

        // R7: both strobes with chip enable: load, no write
        step("R7 priority", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 2'b00, 1'b0, 16'hdead);
        // R8: processor strobe ignored while deselected
        step("R8 ignored hold", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 1'b1, 2'b11, 1'b1, '0);
        step("R8 ignored adv", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22, 1'b1, 2'b11, 1'b1, '0);
        step("R8 ctl loads", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h33, 1'b1, 2'b11, 1'b0, 16'hbeef);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule